// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Guard

This block sits between a CAN protocol controller's transmit output and the transceiver's driver stage. While the driver is in its active mode, it measures how long the transmit line stays dominant (low). A healthy frame never holds the line dominant for more than eleven bit times. If the line stays dominant longer than a programmable number of clock cycles, the block switches the driver off and forces the line it passes to the driver to recessive. This frees the bus for the other nodes.

The fault stays latched until the controller releases the transmit line back to recessive. No timer and no register write can clear it. While the fault is present, an active-low status output is held low. The receive path is a plain pass-through, so the local receiver keeps seeing the real bus during the fault. When the driver leaves active mode, the check stops and any fault is dropped.

The default timeout is 1.2 ms at the chosen clock frequency. With eleven dominant bits as the worst case, this allows data rates down to about 9.2 kbit/s. The timeout must not be set below eleven bit times at the slowest rate in use.

Top module: `can_dto_guard`

## Requirements
- R1: After reset, the status output `flt_n_o` is high and no fault is present. `drv_en_o` stays low until `mode_act_i` is high.
- R2: While `mode_act_i` is low, no dominant length raises a fault. In that case `drv_en_o` equals `mode_act_i` (0).
- R3: A dominant stretch on `txd_i` lasting `TIMEOUT_CYC` clock cycles or fewer raises no fault.
- R4: A dominant stretch lasting more than `TIMEOUT_CYC` cycles raises the fault. Take the first rising clock edge that samples `txd_i` low as edge 0. The fault is raised at edge `TIMEOUT_CYC`+2. While the fault is present, `drv_en_o` is 0, `txd_o` is 1 (recessive) and `flt_n_o` is 0.
- R5: The fault is cleared only by `txd_i` returning to recessive (1). Take the first edge that samples it high as edge 0. The fault is gone after edge 2, and `drv_en_o` returns high.
- R6: `rxd_o` equals `rxd_i` at all times, including while the fault is present.
- R7: When `mode_act_i` goes low during a fault, the fault is cleared at the next clock edge. After a return to active mode with `txd_i` still low, no timing takes place until a fresh high-to-low transition of `txd_i` is seen.
- R8: The cycle counter saturates at `TIMEOUT_CYC`. The fault therefore stays present for a dominant stretch of any length and never drops because the counter wraps.
- R9: Every high-to-low transition of `txd_i` starts a new interval. Dominant stretches separated by recessive gaps are timed one by one and are not added together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_act_i | input | 1 | High while the driver is in its active mode |
| txd_i | input | 1 | Transmit data from the controller (0 = dominant) |
| rxd_i | input | 1 | Receiver output from the bus |
| drv_en_o | output | 1 | Driver enable |
| txd_o | output | 1 | Transmit data passed to the driver, forced to 1 during a fault |
| rxd_o | output | 1 | Receive data passed through to the controller |
| flt_n_o | output | 1 | Dominant-timeout fault status, active low |

## Verification
The transmit input passes through a two-stage synchroniser and an edge register. For this reason, the fault appears at the `TIMEOUT_CYC`+2 edge after dominant is first sampled, and it clears at the second edge after recessive is first sampled. The bench drives inputs on falling clock edges and counts falling edges from the drive. It asserts that the status is still high at falling edge `TIMEOUT_CYC`+2 and low at `TIMEOUT_CYC`+3. It asserts that the status is still low at the second falling edge after release and high at the third. A mode exit takes effect after a single edge, and the pass-through outputs are combinational, so the bench checks them at the first falling edge after the stimulus.

// File: rtl/can_dto_pkg.sv
package can_dto_pkg;
  localparam logic TXD_RECESSIVE = 1'b1;
  localparam int unsigned DEF_CLK_HZ = 50_000_000;
  localparam int unsigned DEF_TIMEOUT_US = 1200;

  function automatic int unsigned cyc_from_us(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/can_dto_sync_edge.sv
module can_dto_sync_edge
  import can_dto_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic d_s_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{TXD_RECESSIVE}};
      prev_q <= TXD_RECESSIVE;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign d_s_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~d_s_o;
  assign rise_o = ~prev_q & d_s_o;
endmodule

// File: rtl/can_dto_timer.sv
module can_dto_timer #(
  parameter int unsigned TIMEOUT_CYC = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_act_i,
  input  logic dom_i,
  input  logic fall_i,
  input  logic rise_i,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (!mode_act_i || rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
    end else if (fall_i) begin
      // fresh interval on every falling edge
      cnt_q   <= CW'(1);
      armed_q <= 1'b1;
    end else if (armed_q && dom_i) begin
      if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LIMIT) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;

  a_r8_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r7_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act_i |=> !fault_q);
  a_r5_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !fault_q);
  a_r4_fault_on_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(dom_i) && $past(mode_act_i));
endmodule

// File: rtl/can_dto_guard.sv
module can_dto_guard
  import can_dto_pkg::*;
#(
  parameter int unsigned CLK_HZ      = DEF_CLK_HZ,
  parameter int unsigned TIMEOUT_CYC = cyc_from_us(CLK_HZ, DEF_TIMEOUT_US),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_act_i,
  input  logic txd_i,
  input  logic rxd_i,
  output logic drv_en_o,
  output logic txd_o,
  output logic rxd_o,
  output logic flt_n_o
);
  logic txd_s, txd_fall, txd_rise, fault;

  can_dto_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (txd_i),
    .d_s_o (txd_s),
    .fall_o(txd_fall),
    .rise_o(txd_rise)
  );

  can_dto_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_act_i(mode_act_i),
    .dom_i     (txd_s != TXD_RECESSIVE),
    .fall_i    (txd_fall),
    .rise_i    (txd_rise),
    .fault_o   (fault)
  );

  assign drv_en_o = mode_act_i & ~fault;
  assign txd_o    = fault ? TXD_RECESSIVE : txd_i;
  assign rxd_o    = rxd_i;
  assign flt_n_o  = ~fault;

  a_r4_driver_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_n_o |-> !drv_en_o && txd_o);
  a_r2_idle_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_act_i && $past(!mode_act_i) |-> flt_n_o);
endmodule

// File: tb/can_dto_guard_tb_top.sv
module can_dto_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 40;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_act = 1'b0, txd = 1'b1, rxd = 1'b1;
  logic drv_en, txd_out, rxd_out, flt_n;
  int checks = 0, failures = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_dto_guard #(.TIMEOUT_CYC(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_act_i(mode_act), .txd_i(txd), .rxd_i(rxd),
    .drv_en_o(drv_en), .txd_o(txd_out), .rxd_o(rxd_out), .flt_n_o(flt_n)
  );

  function automatic bit exp_fault(int n);
    return n > T;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // dominant for n cycles, then release; checks fault presence against model
  task automatic dom_pulse(int n, string req);
    bit seen = 0;
    bit rxd_bad = 0;
    txd = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!flt_n) seen = 1;
      if (rxd_out !== rxd) rxd_bad = 1;
      rxd = 1'($urandom);
    end
    txd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!flt_n) seen = 1;
    end
    check(seen == exp_fault(n), req, seen, exp_fault(n));
    check(!rxd_bad, "R6 rxd pass-through", rxd_bad, 0);
    check(flt_n && drv_en, "R5 cleared after release", flt_n, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flt_n == 1'b1, "R1 status high in reset", flt_n, 1);
    check(drv_en == 1'b0, "R1 driver off in reset", drv_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flt_n == 1'b1 && drv_en == 1'b0, "R1 after reset, mode low", drv_en, 0);

    // R2: long dominant with mode inactive
    txd = 1'b0;
    repeat (3*T) @(negedge clk);
    check(flt_n == 1'b1, "R2 no fault when inactive", flt_n, 1);
    check(drv_en == mode_act, "R2 enable follows mode", drv_en, mode_act);
    txd = 1'b1;
    repeat (4) @(negedge clk);
    mode_act = 1'b1;
    @(negedge clk);
    check(drv_en == 1'b1, "R1 driver on in active mode", drv_en, 1);

    // R3 boundary: exactly T cycles
    dom_pulse(T, "R3 pulse of T cycles no fault");
    dom_pulse(T - 1, "R3 pulse of T-1 cycles no fault");
    // R4 boundary: T+1 cycles
    dom_pulse(T + 1, "R4 pulse of T+1 cycles faults");

    // R4/R5 exact timing
    txd = 1'b0;
    repeat (T + 2) @(negedge clk);
    check(flt_n == 1'b1, "R4 not yet at edge T+1", flt_n, 1);
    @(negedge clk);
    check(flt_n == 1'b0, "R4 fault at edge T+2", flt_n, 0);
    check(drv_en == 1'b0 && txd_out == 1'b1, "R4 driver off, txd recessive", txd_out, 1);
    rxd = 1'b0; #1;
    check(rxd_out == 1'b0, "R6 rxd tracks bus in fault (0)", rxd_out, 0);
    rxd = 1'b1; #1;
    check(rxd_out == 1'b1, "R6 rxd tracks bus in fault (1)", rxd_out, 1);
    // R8: hold long, no wrap
    repeat (3*T) @(negedge clk);
    check(flt_n == 1'b0, "R8 fault held, counter saturates", flt_n, 0);
    txd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(flt_n == 1'b0, "R5 still faulted at edge 1", flt_n, 0);
    @(negedge clk);
    check(flt_n == 1'b1 && drv_en == 1'b1, "R5 cleared at edge 2", flt_n, 1);

    // R9: two sub-timeout pulses with a short gap
    txd = 1'b0;
    repeat (T - 2) @(negedge clk);
    txd = 1'b1;
    repeat (2) @(negedge clk);
    dom_pulse(T - 2, "R9 intervals restart per falling edge");

    // R7: mode exit during fault, re-entry with txd dominant
    txd = 1'b0;
    repeat (T + 4) @(negedge clk);
    check(flt_n == 1'b0, "R7 fault before exit", flt_n, 0);
    mode_act = 1'b0;
    @(negedge clk);
    check(flt_n == 1'b1 && drv_en == 1'b0, "R7 exit clears fault", flt_n, 1);
    mode_act = 1'b1;
    repeat (2*T) @(negedge clk);
    check(flt_n == 1'b1 && drv_en == 1'b1, "R7 no timing without fresh edge", flt_n, 1);
    txd = 1'b1;
    repeat (3) @(negedge clk);
    dom_pulse(T + 5, "R7 fresh edge times again");

    // random pulses
    for (int k = 0; k < 60; k++) begin
      int n = 1 + int'($urandom_range(2*T + 4));
      dom_pulse(n, "R3/R4 random pulse");
      repeat (1 + $urandom_range(6)) @(negedge clk);
    end

    finish_run();
  end
endmodule